// File: doc/BRIEF.md
# Cascadable Display-Data Write Port

This block is the host-facing write port of one display driver core that may be tiled with up to fifteen identical neighbours to cover a larger panel. The host drives a global row address and a global column-byte address with an 8-bit data byte. Every core sees the same bus. Each core compares the upper address bits with its own 4-bit tile position, and only the matching core stores the byte into its local 64-row by 8-byte display buffer.

A second kind of access, read-modify-write, lets the host OR a mask into a stored byte without reading it back first. The core captures the request and raises `busy`. It then fetches the byte and writes back the merged value on its own, so the host is free during that time. While `busy` is high, the core ignores every request. The scan side of the driver reads the buffer through a registered read port.

The sequencer has three states. `ST_IDLE` completes plain writes in a single edge. On an owned read-modify-write request, the transition *accept* moves it to `ST_FETCH`, where the addressed byte is read into a holding register. The transition *merge* then moves it to `ST_MERGE`, where the byte OR the mask is written back. The transition *retire* returns it to `ST_IDLE`. Reset returns the sequencer to `ST_IDLE` from any state.

Top module: `disp_wr_port`

## Requirements
- R1: While `rst` is high at a clock edge, every buffer byte becomes 0x00 and `busy` goes low. After reset, every read returns 0x00 and `busy` reads 0.
- R2: A plain write (`wr_en`=1, `rmw_en`=0) that this core owns and that arrives while `busy` is low stores `wr_data` at local row `row_addr[5:0]` and local byte `col_byte[2:0]` on that rising edge.
- R3: When `wr_en` is 0 at an edge, the buffer does not change and `busy` does not rise, whatever the other inputs are.
- R4: The core owns an access only when `row_addr[7:6]` equals `tile_pos[1:0]` and `col_byte[4:3]` equals `tile_pos[3:2]`. Accesses it does not own leave the buffer and `busy` unchanged.
- R5: An owned read-modify-write (`wr_en`=1, `rmw_en`=1) accepted while `busy` is low raises `busy` for exactly two cycles after the accepting edge. When `busy` falls, the addressed byte holds its old value OR `wr_data`.
- R6: Any request, plain or read-modify-write, presented at an edge where `busy` is high is ignored. It changes no byte and does not extend `busy`.
- R7: A plain write never raises `busy`.
- R8: `rd_data` is registered. After each rising edge it shows the byte at (`rd_row`, `rd_byte`) as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock; all activity on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears buffer and sequencer |
| tile_pos | input | 4 | Tile position: [1:0] row group, [3:2] column group |
| wr_en | input | 1 | Write request qualifier |
| rmw_en | input | 1 | 1 selects read-modify-write (OR merge), 0 a plain write |
| row_addr | input | 8 | Global row address; [7:6] row group, [5:0] local row |
| col_byte | input | 5 | Global column-byte address; [4:3] column group, [2:0] local byte |
| wr_data | input | 8 | Write data, or OR mask for read-modify-write |
| busy | output | 1 | High while a read-modify-write is in progress |
| rd_row | input | 6 | Scan-side read row |
| rd_byte | input | 3 | Scan-side read byte within the row |
| rd_data | output | 8 | Registered scan-side read data |

## Verification
The hardest situation to reach from the ports is a request that lands while the two-cycle merge is still running, one edge into the fetch and again at the write-back edge. The host is free to do this, but it must be lost. A directed sequence starts a read-modify-write and then keeps `wr_en` high into both busy cycles, first with a plain write and then with a second read-modify-write to other owned addresses. It then reads all three locations back and checks that `busy` falls after exactly two cycles. Random traffic mixes owned and foreign addresses across two tile positions, and the whole buffer is compared with a bench model at the end.

// File: rtl/disp_wr_pkg.sv
package disp_wr_pkg;

    // Sequencer states of the write port
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MERGE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/tile_owner_dec.sv
module tile_owner_dec #(
    parameter int GRP_W   = 2,
    parameter int LROW_W  = 6,
    parameter int LBYTE_W = 3,
    localparam int GROW_W = LROW_W + GRP_W,
    localparam int GCOL_W = LBYTE_W + GRP_W,
    localparam int POS_W  = 2 * GRP_W
) (
    input  logic [POS_W-1:0]   tile_pos,
    input  logic [GROW_W-1:0]  row_addr,
    input  logic [GCOL_W-1:0]  col_byte,
    output logic               owned,
    output logic [LROW_W-1:0]  loc_row,
    output logic [LBYTE_W-1:0] loc_byte
);

    logic [GRP_W-1:0] my_row_grp;
    logic [GRP_W-1:0] my_col_grp;
    logic             row_hit;
    logic             col_hit;

    always_comb begin
        my_row_grp = tile_pos[GRP_W-1:0];
        my_col_grp = tile_pos[POS_W-1:GRP_W];
        row_hit    = (row_addr[GROW_W-1:LROW_W] == my_row_grp);
        col_hit    = (col_byte[GCOL_W-1:LBYTE_W] == my_col_grp);
        owned      = row_hit && col_hit;
        loc_row    = row_addr[LROW_W-1:0];
        loc_byte   = col_byte[LBYTE_W-1:0];
    end

endmodule

// File: rtl/disp_buf.sv
module disp_buf #(
    parameter int LROW_W  = 6,
    parameter int LBYTE_W = 3,
    parameter int DW      = 8,
    localparam int NROWS  = 1 << LROW_W,
    localparam int NBYTES = 1 << LBYTE_W
) (
    input  logic               clk,
    input  logic               rst,
    // single write port
    input  logic               we,
    input  logic [LROW_W-1:0]  w_row,
    input  logic [LBYTE_W-1:0] w_byte,
    input  logic [DW-1:0]      w_data,
    // combinational fetch port for the merge sequence
    input  logic [LROW_W-1:0]  f_row,
    input  logic [LBYTE_W-1:0] f_byte,
    output logic [DW-1:0]      f_data,
    // registered scan read port
    input  logic [LROW_W-1:0]  s_row,
    input  logic [LBYTE_W-1:0] s_byte,
    output logic [DW-1:0]      s_data
);

    logic [NBYTES*DW-1:0] row_q [NROWS];
    logic [NROWS-1:0]     row_sel;

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        assign row_sel[r] = we && (w_row == LROW_W'(r));

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q[r] <= '0;
            end else if (row_sel[r]) begin
                row_q[r][w_byte*DW +: DW] <= w_data;
            end
        end
    end

    always_comb begin
        f_data = row_q[f_row][f_byte*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_data <= '0;
        end else begin
            s_data <= row_q[s_row][s_byte*DW +: DW];
        end
    end

    AST_ONE_ROW_SEL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel)) else $error("more than one row selected"); // R2

endmodule

// File: rtl/wr_seq_fsm.sv
module wr_seq_fsm
    import disp_wr_pkg::*;
#(
    parameter int LROW_W  = 6,
    parameter int LBYTE_W = 3,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_plain,
    input  logic               req_rmw,
    input  logic [LROW_W-1:0]  req_row,
    input  logic [LBYTE_W-1:0] req_byte,
    input  logic [DW-1:0]      req_data,
    input  logic [DW-1:0]      fetched,
    output logic               busy,
    output logic               buf_we,
    output logic [LROW_W-1:0]  buf_row,
    output logic [LBYTE_W-1:0] buf_byte,
    output logic [DW-1:0]      buf_data,
    output logic [LROW_W-1:0]  fetch_row,
    output logic [LBYTE_W-1:0] fetch_byte
);

    seq_state_e         state_q;
    seq_state_e         state_d;
    logic [LROW_W-1:0]  hold_row_q;
    logic [LBYTE_W-1:0] hold_byte_q;
    logic [DW-1:0]      hold_mask_q;
    logic [DW-1:0]      hold_old_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_rmw) state_d = ST_FETCH;   // accept
            ST_FETCH: state_d = ST_MERGE;                // merge
            ST_MERGE: state_d = ST_IDLE;                 // retire
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and fetch holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_row_q  <= '0;
            hold_byte_q <= '0;
            hold_mask_q <= '0;
            hold_old_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && req_rmw) begin
                hold_row_q  <= req_row;
                hold_byte_q <= req_byte;
                hold_mask_q <= req_data;
            end
            if (state_q == ST_FETCH) begin
                hold_old_q <= fetched;
            end
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        buf_we     = 1'b0;
        buf_row    = req_row;
        buf_byte   = req_byte;
        buf_data   = req_data;
        fetch_row  = hold_row_q;
        fetch_byte = hold_byte_q;
        unique case (state_q)
            ST_IDLE: begin
                buf_we = req_plain;
            end
            ST_FETCH: begin
                busy = 1'b1;
            end
            ST_MERGE: begin
                busy     = 1'b1;
                buf_we   = 1'b1;
                buf_row  = hold_row_q;
                buf_byte = hold_byte_q;
                buf_data = hold_old_q | hold_mask_q;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy) else $error("busy shorter than two cycles"); // R5
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy) else $error("busy longer than two cycles"); // R6
    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_rmw)) else $error("busy without merge request"); // R5
    AST_PLAIN_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_plain && !req_rmw && !busy) |=> !busy) else $error("plain write raised busy"); // R7

endmodule

// File: rtl/disp_wr_port.sv
module disp_wr_port #(
    parameter int GRP_W   = 2,
    parameter int LROW_W  = 6,
    parameter int LBYTE_W = 3,
    parameter int DW      = 8,
    localparam int GROW_W = LROW_W + GRP_W,
    localparam int GCOL_W = LBYTE_W + GRP_W,
    localparam int POS_W  = 2 * GRP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [POS_W-1:0]   tile_pos,
    input  logic               wr_en,
    input  logic               rmw_en,
    input  logic [GROW_W-1:0]  row_addr,
    input  logic [GCOL_W-1:0]  col_byte,
    input  logic [DW-1:0]      wr_data,
    output logic               busy,
    input  logic [LROW_W-1:0]  rd_row,
    input  logic [LBYTE_W-1:0] rd_byte,
    output logic [DW-1:0]      rd_data
);

    logic               owned;
    logic [LROW_W-1:0]  loc_row;
    logic [LBYTE_W-1:0] loc_byte;
    logic               req_plain;
    logic               req_rmw;
    logic               buf_we;
    logic [LROW_W-1:0]  buf_row;
    logic [LBYTE_W-1:0] buf_byte;
    logic [DW-1:0]      buf_data;
    logic [LROW_W-1:0]  fetch_row;
    logic [LBYTE_W-1:0] fetch_byte;
    logic [DW-1:0]      fetched;

    tile_owner_dec #(
        .GRP_W  (GRP_W),
        .LROW_W (LROW_W),
        .LBYTE_W(LBYTE_W)
    ) owner_i (
        .tile_pos(tile_pos),
        .row_addr(row_addr),
        .col_byte(col_byte),
        .owned   (owned),
        .loc_row (loc_row),
        .loc_byte(loc_byte)
    );

    always_comb begin
        req_plain = wr_en && owned && !rmw_en;
        req_rmw   = wr_en && owned && rmw_en;
    end

    wr_seq_fsm #(
        .LROW_W (LROW_W),
        .LBYTE_W(LBYTE_W),
        .DW     (DW)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .req_plain (req_plain),
        .req_rmw   (req_rmw),
        .req_row   (loc_row),
        .req_byte  (loc_byte),
        .req_data  (wr_data),
        .fetched   (fetched),
        .busy      (busy),
        .buf_we    (buf_we),
        .buf_row   (buf_row),
        .buf_byte  (buf_byte),
        .buf_data  (buf_data),
        .fetch_row (fetch_row),
        .fetch_byte(fetch_byte)
    );

    disp_buf #(
        .LROW_W (LROW_W),
        .LBYTE_W(LBYTE_W),
        .DW     (DW)
    ) buf_i (
        .clk   (clk),
        .rst   (rst),
        .we    (buf_we),
        .w_row (buf_row),
        .w_byte(buf_byte),
        .w_data(buf_data),
        .f_row (fetch_row),
        .f_byte(fetch_byte),
        .f_data(fetched),
        .s_row (rd_row),
        .s_byte(rd_byte),
        .s_data(rd_data)
    );

    AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (wr_en || busy)) else $error("store without write enable"); // R3
    AST_OWNED_ONLY: assert property (@(posedge clk) disable iff (rst)
        (buf_we && !busy) |-> owned) else $error("store for foreign tile"); // R4
    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> !busy) else $error("busy after reset"); // R1

endmodule

// File: tb/disp_wr_port_tb.sv
module disp_wr_port_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] tile_pos;
    logic       wr_en;
    logic       rmw_en;
    logic [7:0] row_addr;
    logic [4:0] col_byte;
    logic [7:0] wr_data;
    logic       busy;
    logic [5:0] rd_row;
    logic [2:0] rd_byte;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [64][8];

    always #2 clk = ~clk;

    disp_wr_port dut_i (
        .clk(clk), .rst(rst), .tile_pos(tile_pos), .wr_en(wr_en),
        .rmw_en(rmw_en), .row_addr(row_addr), .col_byte(col_byte),
        .wr_data(wr_data), .busy(busy), .rd_row(rd_row),
        .rd_byte(rd_byte), .rd_data(rd_data)
    );

    function automatic bit owns(logic [7:0] r, logic [4:0] c, logic [3:0] p);
        return (r[7:6] == p[1:0]) && (c[4:3] == p[3:2]);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // tasks start and end just after a falling edge
    task automatic read_chk(input string req, input logic [5:0] r, input logic [2:0] b);
        rd_row  = r;
        rd_byte = b;
        @(negedge clk);
        check(req, rd_data, model[r][b]);
    endtask

    task automatic apply(input logic we, input logic rmw, input logic [7:0] r,
                         input logic [4:0] c, input logic [7:0] d, input string req);
        bit take;
        take     = we && owns(r, c, tile_pos);
        wr_en    = we;
        rmw_en   = rmw;
        row_addr = r;
        col_byte = c;
        wr_data  = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (take && !rmw) begin
            model[r[5:0]][c[2:0]] = d;
            check(req, {7'd0, busy}, 8'd0);            // R7
        end else if (take && rmw) begin
            check(req, {7'd0, busy}, 8'd1);            // R5 first busy cycle
            @(negedge clk);
            check(req, {7'd0, busy}, 8'd1);            // R5 second busy cycle
            @(negedge clk);
            check(req, {7'd0, busy}, 8'd0);            // R5 released
            model[r[5:0]][c[2:0]] = model[r[5:0]][c[2:0]] | d;
        end else begin
            check(req, {7'd0, busy}, 8'd0);            // R3/R4 no busy
        end
    endtask

    task automatic full_compare(input string req);
        for (int r = 0; r < 64; r++)
            for (int b = 0; b < 8; b++)
                read_chk(req, 6'(r), 3'(b));
    endtask

    task automatic random_ops(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] r;
            logic [4:0] c;
            r = 8'($urandom);
            c = 5'($urandom);
            if ($urandom_range(0, 9) < 7) begin
                r[7:6] = tile_pos[1:0];
                c[4:3] = tile_pos[3:2];
            end
            apply($urandom_range(0, 9) < 8, $urandom_range(0, 9) < 3, r, c,
                  8'($urandom), "R2/R4/R5 random");
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = int'($urandom(32'd7321));
        for (int r = 0; r < 64; r++)
            for (int b = 0; b < 8; b++)
                model[r][b] = 8'h00;
        rst = 1'b1; tile_pos = 4'b1001; wr_en = 1'b0; rmw_en = 1'b0;
        row_addr = '0; col_byte = '0; wr_data = '0; rd_row = '0; rd_byte = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 busy", {7'd0, busy}, 8'd0);
        read_chk("R1 cleared", 6'd0, 3'd0);
        read_chk("R1 cleared", 6'd63, 3'd7);
        // R2 plain owned write: row group 1, column group 2
        apply(1'b1, 1'b0, {2'b01, 6'd5}, {2'b10, 3'd3}, 8'h5A, "R2 plain");
        read_chk("R2 stored", 6'd5, 3'd3);
        // R8 registered read: value before the writing edge
        rd_row = 6'd7; rd_byte = 3'd1;
        wr_en = 1'b1; rmw_en = 1'b0; row_addr = {2'b01, 6'd7};
        col_byte = {2'b10, 3'd1}; wr_data = 8'hC3;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 old value", rd_data, 8'h00);
        model[7][1] = 8'hC3;
        @(negedge clk);
        check("R8 new value", rd_data, 8'hC3);
        // R3 write enable low
        apply(1'b0, 1'b0, {2'b01, 6'd9}, {2'b10, 3'd0}, 8'hFF, "R3 no enable");
        read_chk("R3 unchanged", 6'd9, 3'd0);
        apply(1'b0, 1'b1, {2'b01, 6'd5}, {2'b10, 3'd3}, 8'hFF, "R3 no enable rmw");
        read_chk("R3 unchanged", 6'd5, 3'd3);
        // R4 foreign row group, foreign column group
        apply(1'b1, 1'b0, {2'b10, 6'd10}, {2'b10, 3'd2}, 8'h11, "R4 row group");
        read_chk("R4 unchanged", 6'd10, 3'd2);
        apply(1'b1, 1'b0, {2'b01, 6'd10}, {2'b01, 3'd2}, 8'h22, "R4 column group");
        read_chk("R4 unchanged", 6'd10, 3'd2);
        apply(1'b1, 1'b1, {2'b00, 6'd5}, {2'b10, 3'd3}, 8'hFF, "R4 foreign rmw");
        read_chk("R4 unchanged", 6'd5, 3'd3);
        // R5 read-modify-write merge
        apply(1'b1, 1'b0, {2'b01, 6'd20}, {2'b10, 3'd6}, 8'h0F, "R2 plain");
        apply(1'b1, 1'b1, {2'b01, 6'd20}, {2'b10, 3'd6}, 8'hA0, "R5 rmw");
        read_chk("R5 merged", 6'd20, 3'd6);
        // R6 requests during busy are dropped
        wr_en = 1'b1; rmw_en = 1'b1; row_addr = {2'b01, 6'd30};
        col_byte = {2'b10, 3'd0}; wr_data = 8'h81;
        @(negedge clk);
        model[30][0] = 8'h81;
        rmw_en = 1'b0; row_addr = {2'b01, 6'd31}; wr_data = 8'h77;
        @(negedge clk);
        check("R6 busy fetch", {7'd0, busy}, 8'd1);
        rmw_en = 1'b1; row_addr = {2'b01, 6'd32}; wr_data = 8'h44;
        @(negedge clk);
        wr_en = 1'b0; rmw_en = 1'b0;
        check("R6 busy released", {7'd0, busy}, 8'd0);
        @(negedge clk);
        check("R6 no restart", {7'd0, busy}, 8'd0);
        read_chk("R6 merge target", 6'd30, 3'd0);
        read_chk("R6 plain dropped", 6'd31, 3'd0);
        read_chk("R6 rmw dropped", 6'd32, 3'd0);
        // random traffic, two tile positions
        random_ops(400);
        full_compare("R2/R5 random compare");
        tile_pos = 4'b0110;
        random_ops(300);
        full_compare("R4 second tile compare");
        // R1 reset clears a written buffer
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 64; r++)
            for (int b = 0; b < 8; b++)
                model[r][b] = 8'h00;
        check("R1 busy after reset", {7'd0, busy}, 8'd0);
        full_compare("R1 cleared again");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #600000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule